// File: doc/BRIEF.md
# Element-Level Write-After-Read Overlap Interlock

This block sits at the issue point of a vector unit that can hold more than one vector instruction in flight. Each accepted instruction occupies a slot. The slot records the instruction's two source registers, its vector length and a private copy of the mask register taken when it issued. The execution side asks, slot by slot and cycle by cycle, to read the next source element and to write the next result element. The block answers with same-cycle grants and gives the index of the element each grant covers. Elements of one instruction always go in ascending order, with at most one read and one write per slot per cycle.

When a younger instruction's destination is a register that an older in-flight instruction still has to read, the block does not hold the writer back until the whole register has been consumed. The writer may start once the reader has taken element 0. After that, each of the writer's elements is granted only in a cycle where the reader also fetches an element, and only while the element being written lies strictly below the element being read. The writer therefore trails the reader by at least one element. If the reader pauses, the writer pauses with it. When the reader has consumed its last element, the writer runs freely.

Mask writes update the live mask register at the clock edge. A slot filled in the same cycle keeps the value from before that write. Each pending instruction therefore executes under the mask that was current when it issued, and a later mask update never disturbs it.

Top module: `war_overlap_interlock`

## Requirements
- R1: After reset, issue_ready is 1, issue_slot is 0, slot_mask is all zero, and no rd_gnt or wr_gnt bit is set, even when every request bit is high.
- R2: An instruction is accepted on a clock edge where issue_valid and issue_ready are both 1. issue_slot names the lowest-numbered free slot. issue_ready is 0 while every slot is occupied. issue_vl must lie in 1..64.
- R3: Bit s of rd_req, rd_gnt, wr_req and wr_gnt belongs to slot s, and rd_elem and wr_elem carry slot s in bits [6s+5:6s]. rd_gnt[s] is rd_req[s] while slot s has unread elements. Successive read grants cover elements 0, 1, ..., vl-1. No read grant follows the vl-th one.
- R4: A slot with no recorded conflict gets wr_gnt whenever it requests and has unwritten elements, whatever other slots do. Its write elements ascend from 0.
- R5: A conflict is recorded at issue when the new destination equals either source field of an occupied older slot that still has elements left to read after that cycle. This holds whichever slot positions the two instructions occupy.
- R6: A conflicting writer is not granted element 0 before its reader has been granted element 0. Its earliest first grant is in the cycle where the reader is granted element 1.
- R7: While the conflict holds, a write grant occurs only in a cycle where the older reader is also granted a read, and wr_elem is below that rd_elem. If the reader does not read in a cycle, the writer's grant is withdrawn for that cycle.
- R8: Once the older reader has been granted all of its elements, the conflict is released and the writer is granted on request without any reads.
- R9: A slot becomes free at the clock edge where its last outstanding read or write is granted, and it can accept an instruction in the next cycle.
- R10: slot_mask bits [64s+63:64s] hold the mask register value from before the issue edge of slot s. A mask write in the same cycle as the issue, or in any later cycle, leaves that copy unchanged. The next instruction issued sees the written value.
- R11: An instruction whose destination equals one of its own source fields has no conflict from that match.
- R12: With reader and writer both of length 64 and both requesting every cycle, the writer gets 63 grants during the reader's 64 read cycles. Its element 63 is granted in the cycle after the reader's last read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is offered |
| issue_ready | output | 1 | A free slot exists; offer is taken at the edge |
| issue_dst | input | 3 | Destination vector register |
| issue_src_a | input | 3 | First source vector register |
| issue_src_b | input | 3 | Second source vector register |
| issue_vl | input | 7 | Vector length, 1..64 |
| issue_slot | output | 1 | Slot that the offered instruction will occupy |
| mask_wr_en | input | 1 | Update the live mask register |
| mask_wr_data | input | 64 | New mask value |
| rd_req | input | 2 | Per-slot request to read the next element |
| rd_gnt | output | 2 | Per-slot read grant, same cycle |
| rd_elem | output | 12 | Per-slot index of the element being read |
| wr_req | input | 2 | Per-slot request to write the next element |
| wr_gnt | output | 2 | Per-slot write grant, same cycle |
| wr_elem | output | 12 | Per-slot index of the element being written |
| slot_mask | output | 128 | Per-slot mask copy taken at issue |

## Verification
The hardest state to reach is a conflict pair in which the reader pauses after the writer has started. The writer must then be stopped for exactly that cycle and resume one element behind. The bench holds the writer's request high and drops only the reader's request for a single cycle. Two further cases are built deliberately. In one, the older reader sits in slot 1 and the younger writer in slot 0; the bench fills slot 0 with a one-element instruction, lets it retire, and issues again. In the other, a mask write coincides with an issue edge. A full-length run at vector length 64 checks the trailing last write.

// File: rtl/war_pkg.sv
package war_pkg;
  localparam int NSLOT_DEF = 2;
  localparam int NREG_DEF  = 8;
  localparam int MAXVL_DEF = 64;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/war_slot_alloc.sv
module war_slot_alloc #(
  parameter int NSLOT = 2,
  parameter int SW    = 1
) (
  input  logic [NSLOT-1:0] busy,
  output logic             any_free,
  output logic [SW-1:0]    free_idx
);
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        any_free = 1'b1;
        free_idx = SW'(i);
      end
    end
  end
endmodule

// File: rtl/war_slot_ctx.sv
module war_slot_ctx #(
  parameter int RW    = 3,
  parameter int CW    = 7,
  parameter int MAXVL = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RW-1:0]    ld_src_a,
  input  logic [RW-1:0]    ld_src_b,
  input  logic [CW-1:0]    ld_vl,
  input  logic [MAXVL-1:0] ld_mask,
  input  logic             rd_fire,
  input  logic             wr_fire,
  output logic             busy,
  output logic             rd_done,
  output logic             wr_done,
  output logic             rd_fin,
  output logic [CW-1:0]    rd_cnt,
  output logic [CW-1:0]    wr_cnt,
  output logic [RW-1:0]    src_a,
  output logic [RW-1:0]    src_b,
  output logic [MAXVL-1:0] mask
);
  logic [CW-1:0] vl_q;
  logic          wr_fin;

  assign rd_done = (rd_cnt == vl_q);
  assign wr_done = (wr_cnt == vl_q);
  assign rd_fin  = rd_done | (rd_fire & ((rd_cnt + CW'(1)) == vl_q));
  assign wr_fin  = wr_done | (wr_fire & ((wr_cnt + CW'(1)) == vl_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      vl_q   <= '0;
      rd_cnt <= '0;
      wr_cnt <= '0;
      src_a  <= '0;
      src_b  <= '0;
      mask   <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      vl_q   <= ld_vl;
      rd_cnt <= '0;
      wr_cnt <= '0;
      src_a  <= ld_src_a;
      src_b  <= ld_src_b;
      mask   <= ld_mask;
    end else begin
      if (rd_fire) rd_cnt <= rd_cnt + CW'(1);
      if (wr_fire) wr_cnt <= wr_cnt + CW'(1);
      if (busy && rd_fin && wr_fin) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/war_conflict_track.sv
module war_conflict_track #(
  parameter int NSLOT = 2,
  parameter int RW    = 3,
  parameter int SW    = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [SW-1:0]          load_idx,
  input  logic [RW-1:0]          ld_dst,
  input  logic [NSLOT-1:0]       busy,
  input  logic [NSLOT-1:0]       rd_fin,
  input  logic [NSLOT*RW-1:0]    src_a,
  input  logic [NSLOT*RW-1:0]    src_b,
  output logic [NSLOT*NSLOT-1:0] conf
);
  logic [NSLOT-1:0] hit;
  logic [NSLOT-1:0] conf_q [NSLOT];

  always_comb begin
    for (int o = 0; o < NSLOT; o++) begin
      hit[o] = busy[o] & ~rd_fin[o] &
               ((src_a[o*RW +: RW] == ld_dst) | (src_b[o*RW +: RW] == ld_dst));
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        conf_q[s] <= '0;
      end else begin
        for (int o = 0; o < NSLOT; o++) begin
          if (load && (load_idx == SW'(s))) conf_q[s][o] <= hit[o];
          else if (!busy[s] || rd_fin[o])   conf_q[s][o] <= 1'b0;
        end
      end
    end
    assign conf[s*NSLOT +: NSLOT] = conf_q[s];
  end
endmodule

// File: rtl/war_gate.sv
module war_gate #(
  parameter int NSLOT = 2,
  parameter int CW    = 7
) (
  input  logic [NSLOT-1:0]       busy,
  input  logic [NSLOT-1:0]       rd_done,
  input  logic [NSLOT-1:0]       wr_done,
  input  logic [NSLOT-1:0]       rd_req,
  input  logic [NSLOT-1:0]       wr_req,
  input  logic [NSLOT*CW-1:0]    rd_cnt,
  input  logic [NSLOT*CW-1:0]    wr_cnt,
  input  logic [NSLOT*NSLOT-1:0] conf,
  output logic [NSLOT-1:0]       rd_fire,
  output logic [NSLOT-1:0]       wr_fire
);
  logic [NSLOT-1:0] wr_ok;

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      rd_fire[s] = rd_req[s] & busy[s] & ~rd_done[s];
    end
  end

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      wr_ok[s] = 1'b1;
      for (int o = 0; o < NSLOT; o++) begin
        if (conf[s*NSLOT + o] && !rd_done[o] &&
            !(rd_fire[o] && (wr_cnt[s*CW +: CW] < rd_cnt[o*CW +: CW]))) begin
          wr_ok[s] = 1'b0;
        end
      end
      wr_fire[s] = wr_req[s] & busy[s] & ~wr_done[s] & wr_ok[s];
    end
  end
endmodule

// File: rtl/war_overlap_interlock.sv
module war_overlap_interlock #(
  parameter  int NSLOT = war_pkg::NSLOT_DEF,
  parameter  int NREG  = war_pkg::NREG_DEF,
  parameter  int MAXVL = war_pkg::MAXVL_DEF,
  localparam int RW    = war_pkg::idx_w(NREG),
  localparam int SW    = war_pkg::idx_w(NSLOT),
  localparam int EW    = war_pkg::idx_w(MAXVL),
  localparam int CW    = $clog2(MAXVL + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   issue_valid,
  output logic                   issue_ready,
  input  logic [RW-1:0]          issue_dst,
  input  logic [RW-1:0]          issue_src_a,
  input  logic [RW-1:0]          issue_src_b,
  input  logic [CW-1:0]          issue_vl,
  output logic [SW-1:0]          issue_slot,
  input  logic                   mask_wr_en,
  input  logic [MAXVL-1:0]       mask_wr_data,
  input  logic [NSLOT-1:0]       rd_req,
  output logic [NSLOT-1:0]       rd_gnt,
  output logic [NSLOT*EW-1:0]    rd_elem,
  input  logic [NSLOT-1:0]       wr_req,
  output logic [NSLOT-1:0]       wr_gnt,
  output logic [NSLOT*EW-1:0]    wr_elem,
  output logic [NSLOT*MAXVL-1:0] slot_mask
);
  logic [MAXVL-1:0]       mask_q;
  logic                   any_free;
  logic [SW-1:0]          free_idx;
  logic                   accept;
  logic [NSLOT-1:0]       slot_busy;
  logic [NSLOT-1:0]       rd_done;
  logic [NSLOT-1:0]       wr_done;
  logic [NSLOT-1:0]       rd_fin;
  logic [NSLOT-1:0]       rd_fire;
  logic [NSLOT-1:0]       wr_fire;
  logic [NSLOT*CW-1:0]    rd_cnt_flat;
  logic [NSLOT*CW-1:0]    wr_cnt_flat;
  logic [NSLOT*RW-1:0]    src_a_flat;
  logic [NSLOT*RW-1:0]    src_b_flat;
  logic [NSLOT*NSLOT-1:0] conf_flat;

  always_ff @(posedge clk) begin
    if (!rst_n)          mask_q <= '0;
    else if (mask_wr_en) mask_q <= mask_wr_data;
  end

  war_slot_alloc #(.NSLOT(NSLOT), .SW(SW)) i_alloc (
    .busy     (slot_busy),
    .any_free (any_free),
    .free_idx (free_idx)
  );

  assign issue_ready = any_free;
  assign issue_slot  = free_idx;
  assign accept      = issue_valid & any_free;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    war_slot_ctx #(.RW(RW), .CW(CW), .MAXVL(MAXVL)) i_ctx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept && (free_idx == SW'(s))),
      .ld_src_a (issue_src_a),
      .ld_src_b (issue_src_b),
      .ld_vl    (issue_vl),
      .ld_mask  (mask_q),
      .rd_fire  (rd_fire[s]),
      .wr_fire  (wr_fire[s]),
      .busy     (slot_busy[s]),
      .rd_done  (rd_done[s]),
      .wr_done  (wr_done[s]),
      .rd_fin   (rd_fin[s]),
      .rd_cnt   (rd_cnt_flat[s*CW +: CW]),
      .wr_cnt   (wr_cnt_flat[s*CW +: CW]),
      .src_a    (src_a_flat[s*RW +: RW]),
      .src_b    (src_b_flat[s*RW +: RW]),
      .mask     (slot_mask[s*MAXVL +: MAXVL])
    );
    assign rd_elem[s*EW +: EW] = rd_cnt_flat[s*CW +: EW];
    assign wr_elem[s*EW +: EW] = wr_cnt_flat[s*CW +: EW];
  end

  war_conflict_track #(.NSLOT(NSLOT), .RW(RW), .SW(SW)) i_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_idx (free_idx),
    .ld_dst   (issue_dst),
    .busy     (slot_busy),
    .rd_fin   (rd_fin),
    .src_a    (src_a_flat),
    .src_b    (src_b_flat),
    .conf     (conf_flat)
  );

  war_gate #(.NSLOT(NSLOT), .CW(CW)) i_gate (
    .busy    (slot_busy),
    .rd_done (rd_done),
    .wr_done (wr_done),
    .rd_req  (rd_req),
    .wr_req  (wr_req),
    .rd_cnt  (rd_cnt_flat),
    .wr_cnt  (wr_cnt_flat),
    .conf    (conf_flat),
    .rd_fire (rd_fire),
    .wr_fire (wr_fire)
  );

  assign rd_gnt = rd_fire;
  assign wr_gnt = wr_fire;
endmodule

// File: rtl/war_overlap_interlock_chk.sv
module war_overlap_interlock_chk #(
  parameter int NSLOT = 2,
  parameter int MAXVL = 64,
  parameter int SW    = 1,
  parameter int CW    = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   issue_valid,
  input logic                   issue_ready,
  input logic [SW-1:0]          issue_slot,
  input logic [NSLOT-1:0]       busy,
  input logic [NSLOT-1:0]       rd_gnt,
  input logic [NSLOT-1:0]       wr_gnt,
  input logic [NSLOT*CW-1:0]    rd_cnt,
  input logic [NSLOT*CW-1:0]    wr_cnt,
  input logic [NSLOT*NSLOT-1:0] conf,
  input logic [NSLOT*MAXVL-1:0] slot_mask
);
  assert_accept_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready) |=> busy[$past(issue_slot)]);

  for (genvar s = 0; s < NSLOT; s++) begin : g_s
    assert_read_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_gnt[s] |=> (rd_cnt[s*CW +: CW] == $past(rd_cnt[s*CW +: CW]) + CW'(1)));

    assert_grant_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_gnt[s] || wr_gnt[s]) |-> busy[s]);

    assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy[s] |=> $stable(slot_mask[s*MAXVL +: MAXVL]));

    for (genvar o = 0; o < NSLOT; o++) begin : g_o
      assert_paired_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_gnt[s] && conf[s*NSLOT + o]) |-> rd_gnt[o]);

      assert_write_behind_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_gnt[s] && conf[s*NSLOT + o]) |->
          (wr_cnt[s*CW +: CW] < rd_cnt[o*CW +: CW]));
    end
  end
endmodule

bind war_overlap_interlock war_overlap_interlock_chk #(
  .NSLOT(NSLOT), .MAXVL(MAXVL), .SW(SW), .CW(CW)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .issue_ready (issue_ready),
  .issue_slot  (issue_slot),
  .busy        (slot_busy),
  .rd_gnt      (rd_gnt),
  .wr_gnt      (wr_gnt),
  .rd_cnt      (rd_cnt_flat),
  .wr_cnt      (wr_cnt_flat),
  .conf        (conf_flat),
  .slot_mask   (slot_mask)
);

// File: tb/test_war_overlap_interlock.sv
`timescale 1ns/1ps
module test_war_overlap_interlock;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         issue_valid = 1'b0;
  logic         issue_ready;
  logic [2:0]   issue_dst = '0, issue_src_a = '0, issue_src_b = '0;
  logic [6:0]   issue_vl = 7'd1;
  logic [0:0]   issue_slot;
  logic         mask_wr_en = 1'b0;
  logic [63:0]  mask_wr_data = '0;
  logic [1:0]   rd_req = '0, wr_req = '0, rd_gnt, wr_gnt;
  logic [11:0]  rd_elem, wr_elem;
  logic [127:0] slot_mask;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [1:0] rg;
    logic [1:0] wg;
    int er [2];
    int ew [2];
    string tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  war_overlap_interlock i_war_overlap_interlock (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_dst(issue_dst), .issue_src_a(issue_src_a), .issue_src_b(issue_src_b),
    .issue_vl(issue_vl), .issue_slot(issue_slot), .mask_wr_en(mask_wr_en),
    .mask_wr_data(mask_wr_data), .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_elem(rd_elem),
    .wr_req(wr_req), .wr_gnt(wr_gnt), .wr_elem(wr_elem), .slot_mask(slot_mask)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // driver: one grant cycle, expectation goes to the scoreboard
  task automatic step(input logic [1:0] rd, input logic [1:0] wr,
                      input logic [1:0] rg, input logic [1:0] wg,
                      input int er0, input int er1, input int ew0, input int ew1,
                      input string tag);
    item_t it;
    @(negedge clk);
    rd_req = rd;
    wr_req = wr;
    it.rg = rg; it.wg = wg;
    it.er[0] = er0; it.er[1] = er1; it.ew[0] = ew0; it.ew[1] = ew1;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compares the design against the queued expectation each cycle
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(rd_gnt == it.rg, {it.tag, " rd_gnt"}, 128'(rd_gnt), 128'(it.rg));
        check(wr_gnt == it.wg, {it.tag, " wr_gnt"}, 128'(wr_gnt), 128'(it.wg));
        for (int s = 0; s < 2; s++) begin
          if (it.rg[s])
            check(int'(rd_elem[s*6 +: 6]) == it.er[s], {it.tag, " rd_elem"},
                  128'(rd_elem[s*6 +: 6]), 128'(it.er[s]));
          if (it.wg[s])
            check(int'(wr_elem[s*6 +: 6]) == it.ew[s], {it.tag, " wr_elem"},
                  128'(wr_elem[s*6 +: 6]), 128'(it.ew[s]));
        end
      end
    end
  end

  task automatic issue(input int dst, input int sa, input int sb, input int vl,
                       input int exp_slot, input bit mw, input logic [63:0] md,
                       input string tag);
    @(negedge clk);
    rd_req = '0; wr_req = '0;
    issue_valid = 1'b1;
    issue_dst = 3'(dst); issue_src_a = 3'(sa); issue_src_b = 3'(sb);
    issue_vl = 7'(vl);
    mask_wr_en = mw; mask_wr_data = md;
    #2;
    check(issue_ready == 1'b1, {tag, " R2 ready"}, 128'(issue_ready), 128'(1));
    check(int'(issue_slot) == exp_slot, {tag, " R2 slot"}, 128'(issue_slot), 128'(exp_slot));
    @(posedge clk);
    #1;
    issue_valid = 1'b0;
    mask_wr_en = 1'b0;
  endtask

  task automatic mask_write(input logic [63:0] md);
    @(negedge clk);
    mask_wr_en = 1'b1; mask_wr_data = md;
    @(posedge clk);
    #1;
    mask_wr_en = 1'b0;
  endtask

  task automatic drain(input string tag);
    @(negedge clk);
    rd_req = 2'b11; wr_req = 2'b11;
    repeat (80) @(negedge clk);
    rd_req = '0; wr_req = '0;
    #2;
    check(issue_ready == 1'b1 && issue_slot == 1'b0, {tag, " R9 all slots free"},
          128'({issue_ready, issue_slot}), 128'(2'b10));
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, requests on empty slots are refused
    @(negedge clk);
    rd_req = 2'b11; wr_req = 2'b11;
    #2;
    check(issue_ready == 1'b1, "R1 ready", 128'(issue_ready), 128'(1));
    check(issue_slot == 1'b0, "R1 slot", 128'(issue_slot), 128'(0));
    check(rd_gnt == 2'b00 && wr_gnt == 2'b00, "R1 no grants",
          128'({rd_gnt, wr_gnt}), 128'(0));
    check(slot_mask == '0, "R1 mask zero", slot_mask, 128'(0));

    // Scenario B: reader slot0 (srcs 1,2), writer slot1 dst 1 (R5 src_a)
    issue(3, 1, 2, 4, 0, 0, '0, "B0");
    issue(1, 4, 5, 4, 1, 0, '0, "B1");
    #2;
    check(issue_ready == 1'b0, "R2 full", 128'(issue_ready), 128'(0));
    step(2'b01, 2'b11, 2'b01, 2'b01, 0, 0, 0, 0, "R6 R4 B c1");
    step(2'b01, 2'b11, 2'b01, 2'b11, 1, 0, 1, 0, "R6 R3 B c2");
    step(2'b00, 2'b11, 2'b00, 2'b01, 0, 0, 2, 0, "R7 stall B c3");
    step(2'b01, 2'b11, 2'b01, 2'b11, 2, 0, 3, 1, "R7 B c4");
    step(2'b01, 2'b11, 2'b01, 2'b10, 3, 0, 0, 2, "R7 B c5");
    step(2'b01, 2'b11, 2'b00, 2'b10, 0, 0, 0, 3, "R8 R3 B c6");
    #3;
    check(issue_ready == 1'b1 && issue_slot == 1'b0, "R9 slot0 freed",
          128'({issue_ready, issue_slot}), 128'(2'b10));
    step(2'b10, 2'b11, 2'b10, 2'b00, 0, 0, 0, 0, "R3 R4 B c7");
    drain("B");

    // Scenario C: conflict through src_b, release after reader is done
    issue(3, 1, 2, 2, 0, 0, '0, "C0");
    issue(2, 6, 7, 2, 1, 0, '0, "C1");
    step(2'b01, 2'b10, 2'b01, 2'b00, 0, 0, 0, 0, "R5 srcb C c1");
    step(2'b01, 2'b10, 2'b01, 2'b10, 1, 0, 0, 0, "R6 C c2");
    step(2'b00, 2'b10, 2'b00, 2'b10, 0, 0, 0, 1, "R8 C c3");
    drain("C");

    // Scenario D: no conflict; writer's own source equals its dst
    issue(3, 1, 2, 3, 0, 0, '0, "D0");
    issue(6, 6, 5, 3, 1, 0, '0, "D1");
    step(2'b01, 2'b10, 2'b01, 2'b10, 0, 0, 0, 0, "R4 R11 D c1");
    step(2'b00, 2'b10, 2'b00, 2'b10, 0, 0, 0, 1, "R4 R11 D c2");
    drain("D");

    // Scenario E: older reader in slot1, younger writer in slot0
    issue(5, 5, 5, 1, 0, 0, '0, "E0");
    issue(7, 4, 4, 3, 1, 0, '0, "E1");
    step(2'b01, 2'b01, 2'b01, 2'b01, 0, 0, 0, 0, "R4 R9 E fin");
    issue(4, 0, 0, 2, 0, 0, '0, "E2 R9 reuse");
    step(2'b10, 2'b01, 2'b10, 2'b00, 0, 0, 0, 0, "R5 R6 E c1");
    step(2'b10, 2'b01, 2'b10, 2'b01, 0, 1, 0, 0, "R7 E c2");
    drain("E");

    // Scenario M: mask snapshots
    mask_write(64'h1111_2222_3333_4444);
    issue(1, 2, 3, 1, 0, 1, 64'hAAAA_BBBB_CCCC_DDDD, "M0");
    issue(4, 5, 6, 1, 1, 0, '0, "M1");
    mask_write(64'h5555_6666_7777_8888);
    #2;
    check(slot_mask[63:0] == 64'h1111_2222_3333_4444, "R10 slot0 copy",
          128'(slot_mask[63:0]), 128'(64'h1111_2222_3333_4444));
    check(slot_mask[127:64] == 64'hAAAA_BBBB_CCCC_DDDD, "R10 slot1 copy",
          128'(slot_mask[127:64]), 128'(64'hAAAA_BBBB_CCCC_DDDD));
    drain("M");
    issue(1, 2, 3, 1, 0, 0, '0, "M2");
    #2;
    check(slot_mask[63:0] == 64'h5555_6666_7777_8888, "R10 new copy",
          128'(slot_mask[63:0]), 128'(64'h5555_6666_7777_8888));
    drain("M2");

    // Scenario L: full length overlap at vl 64
    issue(1, 2, 3, 64, 0, 0, '0, "L0");
    issue(2, 5, 6, 64, 1, 0, '0, "L1");
    for (int c = 0; c <= 64; c++) begin
      step(2'b01, 2'b10, (c < 64) ? 2'b01 : 2'b00, (c >= 1) ? 2'b10 : 2'b00,
           c, 0, 0, c - 1, "R12 vl64");
    end
    drain("L");

    repeat (3) @(negedge clk);
    summary();
  end
endmodule